// File: doc/BRIEF.md
# Dual-Channel Sample Output Coder

This block sits at the output of a two-channel, 12-bit sampling front end. Samples arrive in plain offset-binary form, and the block re-codes them into the format that the downstream receiver expects. There are three formats: offset binary (passed through unchanged), two's complement and reflected Gray code. Both channels share one valid flag. Each pair of samples is coded with a single format and then registered.

The format comes from a 3-bit control field, written through a simple register write port. While that field holds zero, a tri-level board strap decides the format. A board can therefore come up in the right coding with no software, and firmware can still take over control later. A hard reset clears the field. A soft reset flushes the output stage but leaves the field as it was, so a running system keeps its coding when its datapath is cleaned.

Top module: `smp_code_conv`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. The coded data for a sample appears on `out_a`/`out_b` in the same cycle as its `out_valid`.
- R2: With control field 3'b001, each output is its input with the most significant bit inverted (two's complement).
- R3: With control field 3'b010, each output is `d ^ (d >> 1)` of its input (Gray code).
- R4: With control field 3'b100, each output equals its input (offset binary).
- R5: With control field 3'b000, `strap` chooses the format: 2'b00 gives offset binary, 2'b01 gives two's complement, 2'b10 gives Gray, and 2'b11 (the floating, mid-level strap) gives two's complement.
- R6: The nonzero field values 3'b011, 3'b101, 3'b110 and 3'b111 are not coding selections, and with any of them the strap decides exactly as in R5.
- R7: A `soft_rst` pulse clears `out_valid`, `out_a` and `out_b` to zero on the next clock and leaves the control field unchanged.
- R8: After the asynchronous `rst_n`, `out_valid`, `out_a` and `out_b` are zero and the control field is 3'b000.
- R9: Both channels of one sample are coded with the same format. A sample accepted in the same cycle as a control write uses the old setting, and the next sample uses the new one.
- R10: While `in_valid` is low, `out_a` and `out_b` keep their last values and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous datapath flush; keeps the control field |
| cfg_we | input | 1 | Write strobe for the format control field |
| cfg_wdata | input | 3 | New value of the format control field |
| strap | input | 2 | Tri-level strap decode (00 low, 01 mid/float, 10 high, 11 mid) |
| in_valid | input | 1 | Input sample pair is valid |
| in_a | input | 12 | Channel A sample, offset binary |
| in_b | input | 12 | Channel B sample, offset binary |
| out_valid | output | 1 | Coded sample pair is valid |
| out_a | output | 12 | Channel A coded sample |
| out_b | output | 12 | Channel B coded sample |

## Verification
The checker watches five things on every cycle: that valid is delayed by exactly one clock, that each output matches the coding the control field and strap select for the previous input, that held data stays put while valid is low, that soft reset flushes the outputs, and that soft reset keeps the control field. Some behaviour can only be shown by the bench's scenarios. These are the reset state, the strap fallback for each of the four reserved codes, the old-versus-new format split around a write, and the boundary values 0x000, 0x7FF, 0x800 and 0xFFF.

// File: rtl/smp_code_pkg.sv
package smp_code_pkg;

   localparam int unsigned CFG_W = 3;

   typedef enum logic [1:0] {
      CODE_OFFSET = 2'd0,
      CODE_TWOS   = 2'd1,
      CODE_GRAY   = 2'd2
   } code_e;

   localparam logic [CFG_W-1:0] CFG_STRAP  = 3'b000;
   localparam logic [CFG_W-1:0] CFG_TWOS   = 3'b001;
   localparam logic [CFG_W-1:0] CFG_GRAY   = 3'b010;
   localparam logic [CFG_W-1:0] CFG_OFFSET = 3'b100;

   localparam logic [1:0] STRAP_LOW   = 2'b00;
   localparam logic [1:0] STRAP_MID   = 2'b01;
   localparam logic [1:0] STRAP_HIGH  = 2'b10;

   function automatic code_e strap_to_code(input logic [1:0] s);
      code_e c;
      case (s)
         STRAP_LOW:  c = CODE_OFFSET;
         STRAP_HIGH: c = CODE_GRAY;
         default:    c = CODE_TWOS;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/smp_fmt_select.sv
module smp_fmt_select
   import smp_code_pkg::*;
#(
   parameter int unsigned FIELD_W = CFG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [FIELD_W-1:0] cfg_wdata,
   input  logic [1:0]         strap,
   output logic [FIELD_W-1:0] fmt_q,
   output code_e              code
);

   if (FIELD_W != CFG_W) begin : g_bad_field
      $error("smp_fmt_select: FIELD_W must equal CFG_W");
   end

   // Control field: hard reset only; soft reset is deliberately absent.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q <= CFG_STRAP;
      end else if (cfg_we) begin
         fmt_q <= cfg_wdata;
      end
   end

   always_comb begin
      case (fmt_q)
         CFG_TWOS:   code = CODE_TWOS;
         CFG_GRAY:   code = CODE_GRAY;
         CFG_OFFSET: code = CODE_OFFSET;
         default:    code = strap_to_code(strap);
      endcase
   end

endmodule

// File: rtl/smp_code_lane.sv
module smp_code_lane
   import smp_code_pkg::*;
#(
   parameter int unsigned DATA_W     = 12,
   parameter bit          GRAY_CHAIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              in_valid,
   input  code_e             code,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   localparam int unsigned MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("smp_code_lane: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] gray_w;
   logic [DATA_W-1:0] twos_w;
   logic [DATA_W-1:0] coded_w;

   if (GRAY_CHAIN) begin : g_gray_chain
      assign gray_w[MSB] = din[MSB];
      for (genvar i = 0; i < MSB; i++) begin : g_bit
         assign gray_w[i] = din[i] ^ din[i+1];
      end
   end else begin : g_gray_shift
      assign gray_w = din ^ (din >> 1);
   end

   assign twos_w = {~din[MSB], din[MSB-1:0]};

   always_comb begin
      case (code)
         CODE_TWOS: coded_w = twos_w;
         CODE_GRAY: coded_w = gray_w;
         default:   coded_w = din;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
      end else if (soft_rst) begin
         dout <= '0;
      end else if (in_valid) begin
         dout <= coded_w;
      end
   end

endmodule

// File: rtl/smp_code_conv.sv
module smp_code_conv
   import smp_code_pkg::*;
#(
   parameter int unsigned DATA_W     = 12,
   parameter bit          GRAY_CHAIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_wdata,
   input  logic [1:0]        strap,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_a,
   output logic [DATA_W-1:0] out_b
);

   localparam int unsigned N_CH = 2;

   logic [CFG_W-1:0]  fmt_q;
   code_e             code;
   logic [DATA_W-1:0] din_arr  [N_CH];
   logic [DATA_W-1:0] dout_arr [N_CH];

   assign din_arr[0] = in_a;
   assign din_arr[1] = in_b;

   smp_fmt_select #(.FIELD_W(CFG_W)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .strap     (strap),
      .fmt_q     (fmt_q),
      .code      (code)
   );

   // One resolved code feeds every lane, so a pair never mixes formats.
   for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
      smp_code_lane #(.DATA_W(DATA_W), .GRAY_CHAIN(GRAY_CHAIN)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_rst (soft_rst),
         .in_valid (in_valid),
         .code     (code),
         .din      (din_arr[ch]),
         .dout     (dout_arr[ch])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid & ~soft_rst;
      end
   end

   assign out_a = dout_arr[0];
   assign out_b = dout_arr[1];

endmodule

// File: rtl/smp_code_conv_chk.sv
module smp_code_conv_chk
   import smp_code_pkg::*;
#(
   parameter int unsigned DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              cfg_we,
   input logic [2:0]        fmt_q,
   input logic [1:0]        strap,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_a,
   input logic [DATA_W-1:0] in_b,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_a,
   input logic [DATA_W-1:0] out_b
);

   localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

   logic sel_twos, sel_gray, sel_off;
   always_comb begin
      sel_twos = (fmt_q == 3'b001) ||
                 (!(fmt_q inside {3'b001, 3'b010, 3'b100}) && (strap inside {2'b01, 2'b11}));
      sel_gray = (fmt_q == 3'b010) ||
                 (!(fmt_q inside {3'b001, 3'b010, 3'b100}) && (strap == 2'b10));
      sel_off  = (fmt_q == 3'b100) ||
                 (!(fmt_q inside {3'b001, 3'b010, 3'b100}) && (strap == 2'b00));
   end

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == ($past(in_valid) && !$past(soft_rst))) else $error("valid delay"); // R1

   AST_TWOS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !soft_rst && sel_twos) |=>
         (out_a == ($past(in_a) ^ TOP_BIT)) && (out_b == ($past(in_b) ^ TOP_BIT))) else $error("twos"); // R2

   AST_GRAY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !soft_rst && sel_gray) |=>
         (out_a == ($past(in_a) ^ ($past(in_a) >> 1))) &&
         (out_b == ($past(in_b) ^ ($past(in_b) >> 1)))) else $error("gray"); // R3

   AST_OFFSET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !soft_rst && sel_off) |=>
         (out_a == $past(in_a)) && (out_b == $past(in_b))) else $error("offset"); // R4

   AST_SOFT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!out_valid && out_a == '0 && out_b == '0)) else $error("flush"); // R7

   AST_SOFT_KEEPS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !cfg_we) |=> $stable(fmt_q)) else $error("field kept"); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !soft_rst) |=> ($stable(out_a) && $stable(out_b) && !out_valid)) else $error("hold"); // R10

endmodule

bind smp_code_conv smp_code_conv_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .soft_rst  (soft_rst),
   .cfg_we    (cfg_we),
   .fmt_q     (fmt_q),
   .strap     (strap),
   .in_valid  (in_valid),
   .in_a      (in_a),
   .in_b      (in_b),
   .out_valid (out_valid),
   .out_a     (out_a),
   .out_b     (out_b)
);

// File: tb/tb_smp_code_conv.sv
`timescale 1ns/1ps
module tb_smp_code_conv;

   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         soft_rst = 1'b0;
   logic         cfg_we = 1'b0;
   logic [2:0]   cfg_wdata = 3'b000;
   logic [1:0]   strap = 2'b00;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_a = '0;
   logic [W-1:0] in_b = '0;
   logic         out_valid;
   logic [W-1:0] out_a;
   logic [W-1:0] out_b;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   smp_code_conv dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .strap(strap), .in_valid(in_valid),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
   );

   // fmt: 0 offset, 1 twos, 2 gray
   function automatic logic [W-1:0] enc(input int fmt, input logic [W-1:0] d);
      if (fmt == 1) return d ^ 12'h800;
      if (fmt == 2) return d ^ (d >> 1);
      return d;
   endfunction

   function automatic int strap_fmt(input logic [1:0] s);
      if (s == 2'b00) return 0;
      if (s == 2'b10) return 2;
      return 1;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [2:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Present one pair at a negedge, look at the outputs one negedge later.
   task automatic send_check(input string req, input int fmt, input logic [W-1:0] a, input logic [W-1:0] b);
      in_valid = 1'b1; in_a = a; in_b = b;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, {31'd0, out_valid}, 32'd1);
      check({req, " ch a"}, {20'd0, out_a}, {20'd0, enc(fmt, a)});
      check({req, " ch b"}, {20'd0, out_b}, {20'd0, enc(fmt, b)});
   endtask

   task automatic t_reset();
      check("R8 valid", {31'd0, out_valid}, 32'd0);
      check("R8 a", {20'd0, out_a}, 32'd0);
      check("R8 b", {20'd0, out_b}, 32'd0);
      strap = 2'b10;
      send_check("R8 field 000 after reset", 2, 12'hA5C, 12'h3C1);
   endtask

   task automatic t_register_codes();
      strap = 2'b00;
      write_cfg(3'b001);
      send_check("R2", 1, 12'h800, 12'h7FF);
      send_check("R2", 1, 12'h000, 12'hFFF);
      write_cfg(3'b010);
      send_check("R3", 2, 12'hFFF, 12'h800);
      send_check("R3", 2, 12'h7FF, 12'h555);
      write_cfg(3'b100);
      strap = 2'b10;
      send_check("R4", 0, 12'h123, 12'hFED);
      send_check("R4", 0, 12'h800, 12'h000);
   endtask

   task automatic t_strap();
      write_cfg(3'b000);
      for (int s = 0; s < 4; s++) begin
         strap = s[1:0];
         send_check("R5", strap_fmt(s[1:0]), 12'h9B3, 12'h46C);
      end
   endtask

   task automatic t_reserved();
      logic [2:0] codes [4] = '{3'b011, 3'b101, 3'b110, 3'b111};
      for (int k = 0; k < 4; k++) begin
         write_cfg(codes[k]);
         strap = k[1:0];
         send_check("R6", strap_fmt(k[1:0]), 12'hC37, 12'h801);
      end
   endtask

   task automatic t_soft_reset();
      write_cfg(3'b010);
      strap = 2'b00;
      in_valid = 1'b1; in_a = 12'hABC; in_b = 12'h123; soft_rst = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; soft_rst = 1'b0;
      check("R7 valid", {31'd0, out_valid}, 32'd0);
      check("R7 a", {20'd0, out_a}, 32'd0);
      check("R7 b", {20'd0, out_b}, 32'd0);
      send_check("R7 field kept", 2, 12'h6D2, 12'hF0F);
   endtask

   task automatic t_switch();
      write_cfg(3'b001);
      // write and sample share a cycle: old setting (twos) applies
      cfg_we = 1'b1; cfg_wdata = 3'b010;
      send_check("R9 old", 1, 12'h3A7, 12'hC58);
      cfg_we = 1'b0;
      send_check("R9 new", 2, 12'h3A7, 12'hC58);
      send_check("R1", 2, 12'h001, 12'hFFE);
   endtask

   task automatic t_hold();
      write_cfg(3'b100);
      send_check("R10 load", 0, 12'h5A5, 12'hA5A);
      in_a = 12'h111; in_b = 12'h222;
      @(negedge clk);
      @(negedge clk);
      check("R10 valid low", {31'd0, out_valid}, 32'd0);
      check("R10 a held", {20'd0, out_a}, 32'h5A5);
      check("R10 b held", {20'd0, out_b}, 32'hA5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_register_codes();
      t_strap();
      t_reserved();
      t_soft_reset();
      t_switch();
      t_hold();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule